// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous Memory

This block is a synchronous memory of parameterised depth that holds words made of four 9-bit lanes. Each lane carries 8 data bits and 1 parity bit. Every command input is captured on the rising clock edge into a command stage. The array is written, or read into an output register, on the following edge. The read word is therefore presented one registered stage after the command was taken. A surrounding pad ring joins the separate inbound word, outbound word and drive-enable pins into one shared bus.

A cycle is an access only when three chip selects are all active and the access request is low. The cycle is a write when the global write enable is low, or when the byte write enable is low together with at least one lane select. Any other access is a read. The drive enable goes high only for a registered read. It is gated at once by the output enable. It is held low while a write sits in the command stage, and for the first read that follows a deselected cycle.

A sleep input quiets the block, but it is honoured only when the chips are deselected. After sleep is released, commands are ignored for a fixed number of cycles. The burst address sequencing lives outside this block and arrives on the plain address port.

Top module: `bytelane_sram`

## Requirements
- R1: A read captured at clock edge n appears on `dq_out`, with `dq_oe` high, after edge n+1. This holds when the previous cycle was selected, `oe_n` is low and no write was captured at edge n+1.
- R2: A write with `gwe_n` low stores all four lanes of `dq_in`, whatever `bwe_n` and `bsel_n` are.
- R3: With `gwe_n` high, lane i is stored only when `bwe_n` is low and `bsel_n[i]` is low. Lane i is bits [9i+8:9i] and bit 9i+8 is its parity bit. Lanes that are not stored keep their old contents.
- R4: An access with `gwe_n` high and no lane stored (`bwe_n` high, or `bsel_n` all ones) is a read and changes no stored word.
- R5: While a write is held in the command stage (captured at the last edge), `dq_oe` is low even when `oe_n` is low and a read result is pending.
- R6: For a read whose previous cycle was deselected, `dq_oe` stays low during its output cycle.
- R7: The block is selected only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0. A write attempted with any single select inactive leaves memory unchanged.
- R8: Sleep is entered only when `sleep` is high at an edge where the block is deselected. While asleep, no command is accepted and `dq_oe` is low. A `sleep` request made while the block is selected is refused, and that cycle's access proceeds.
- R9: After `sleep` is sampled low, the commands captured at the next two edges are ignored. The command captured at the third edge is accepted.
- R10: A read captured at the edge directly after a write to the same address returns the newly written word.
- R11: `oe_n` gates `dq_oe` combinationally, with no clock edge needed.
- R12: During and right after reset, `dq_oe` is low and the block counts as coming from a deselected state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| req_n | input | 1 | Access request, active low |
| addr | input | ADDR_W | Word address from the burst address port |
| gwe_n | input | 1 | Global write enable, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bsel_n | input | LANES | Per-lane select, active low |
| dq_in | input | LANES*LANE_W | Inbound write word |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Sleep request |
| dq_out | output | LANES*LANE_W | Registered read word |
| dq_oe | output | 1 | Bus drive enable |

## Verification
A wrong lane mask corrupts only some 9-bit lanes. It shows on the read of that address one edge after the read command, as a word that differs from the model in exactly those lanes. A stuck deselect history or a broken sleep or wake counter shows in the very next output cycle: `dq_oe` is high when it should be low, or low when it should be high. A stuck wake counter can also drop a write, which only shows on a later read back. A drive gate that ignores the write in the command stage shows in the first cycle in which a read result and a write overlap.

// File: rtl/bls_pkg.sv
package bls_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/bls_cmd_stage.sv
module bls_cmd_stage
  import bls_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int LANES    = 4,
  parameter int LANE_W   = 9,
  parameter int WAKE_CYC = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs0_n,
  input  logic                      cs1,
  input  logic                      cs2_n,
  input  logic                      req_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      gwe_n,
  input  logic                      bwe_n,
  input  logic [LANES-1:0]          bsel_n,
  input  logic [LANES*LANE_W-1:0]   dq_in,
  input  logic                      sleep,
  output op_e                       op_q,
  output logic [ADDR_W-1:0]         addr_q,
  output logic [LANES*LANE_W-1:0]   wdata_q,
  output logic [LANES-1:0]          lmask_q,
  output logic                      first_q,
  output logic                      asleep_q
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int CNT_W  = $clog2(WAKE_CYC + 1);

  logic             selected;
  logic             access;
  logic             asleep_d;
  logic             desel_q;
  logic [CNT_W-1:0] wake_cnt;
  logic [LANES-1:0] lane_mask_c;
  op_e              op_c;

  always_comb begin
    selected = !cs0_n && cs1 && !cs2_n;
    if (!gwe_n)      lane_mask_c = '1;
    else if (!bwe_n) lane_mask_c = ~bsel_n;
    else             lane_mask_c = '0;
    access   = selected && !req_n && !asleep_q && (wake_cnt == '0);
    if (!access)           op_c = OP_IDLE;
    else if (|lane_mask_c) op_c = OP_WRITE;
    else                   op_c = OP_READ;
    asleep_d = sleep && (asleep_q || !selected);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q     <= OP_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      lmask_q  <= '0;
      first_q  <= 1'b1;
      desel_q  <= 1'b1;
      asleep_q <= 1'b0;
      wake_cnt <= '0;
    end else begin
      op_q     <= op_c;
      lmask_q  <= access ? lane_mask_c : '0;
      if (access) begin
        addr_q  <= addr;
        wdata_q <= DATA_W'(dq_in);
      end
      first_q  <= desel_q;
      desel_q  <= !selected;
      asleep_q <= asleep_d;
      if (asleep_q && !asleep_d)  wake_cnt <= CNT_W'(WAKE_CYC);
      else if (wake_cnt != '0)    wake_cnt <= wake_cnt - 1'b1;
    end
  end

  AST_GW_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !gwe_n) |=> ($countones(lmask_q) == LANES)); // R2
  AST_SLEEP_ONLY_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep_q) |-> $past(!selected)); // R8
  AST_SLEEP_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    asleep_q |=> (op_q == OP_IDLE)); // R8
  AST_WAKE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_cnt != '0) |=> (op_q == OP_IDLE)); // R9
endmodule

// File: rtl/bls_array.sv
module bls_array #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[i]) mem[addr] <= wdata[i*LANE_W +: LANE_W];
    end
    assign rdata[i*LANE_W +: LANE_W] = mem[addr];
  end
endmodule

// File: rtl/bls_out_stage.sv
module bls_out_stage
  import bls_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op_q,
  input  logic              first_q,
  input  logic [DATA_W-1:0] rdata,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  logic              rd_q;
  logic              mask_q;
  logic [DATA_W-1:0] dout_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      mask_q <= 1'b0;
      dout_q <= '0;
    end else begin
      rd_q   <= (op_q == OP_READ);
      mask_q <= first_q;
      if (op_q == OP_READ) dout_q <= rdata;
    end
  end

  assign dq_out = dout_q;
  assign dq_oe  = !oe_n && rd_q && !mask_q && (op_q != OP_WRITE);

  AST_MASK_AFTER_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_READ && first_q) |=> !dq_oe); // R6
endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
  import bls_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int LANES    = 4,
  parameter int LANE_W   = 9,
  parameter int WAKE_CYC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs0_n,
  input  logic                    cs1,
  input  logic                    cs2_n,
  input  logic                    req_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    gwe_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bsel_n,
  input  logic [LANES*LANE_W-1:0] dq_in,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);
  localparam int DATA_W = LANES * LANE_W;

  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  lmask_q;
  logic              first_q;
  logic              asleep_q;
  logic [DATA_W-1:0] rdata;

  bls_cmd_stage #(
    .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .WAKE_CYC(WAKE_CYC)
  ) u_cmd (
    .clk(clk), .rst_n(rst_n), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .req_n(req_n), .addr(addr), .gwe_n(gwe_n), .bwe_n(bwe_n),
    .bsel_n(bsel_n), .dq_in(dq_in), .sleep(sleep), .op_q(op_q),
    .addr_q(addr_q), .wdata_q(wdata_q), .lmask_q(lmask_q),
    .first_q(first_q), .asleep_q(asleep_q)
  );

  bls_array #(
    .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
  ) u_array (
    .clk(clk), .we(lmask_q), .addr(addr_q), .wdata(wdata_q), .rdata(rdata)
  );

  bls_out_stage #(
    .DATA_W(DATA_W)
  ) u_out (
    .clk(clk), .rst_n(rst_n), .op_q(op_q), .first_q(first_q),
    .rdata(rdata), .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  AST_ASLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(asleep_q) |-> !dq_oe); // R8
endmodule

// File: tb/tb_bytelane_sram.sv
module tb_bytelane_sram;
  localparam int AW = 4;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs0_n = 1'b1, cs1 = 1'b0, cs2_n = 1'b1, req_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          gwe_n = 1'b1, bwe_n = 1'b1;
  logic [3:0]    bsel_n = 4'hF;
  logic [DW-1:0] dq_in = '0;
  logic          oe_n = 1'b0, sleep = 1'b0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [DW-1:0] model [16];

  always #4 clk = ~clk;

  bytelane_sram dut (
    .clk(clk), .rst_n(rst_n), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .req_n(req_n), .addr(addr), .gwe_n(gwe_n), .bwe_n(bwe_n),
    .bsel_n(bsel_n), .dq_in(dq_in), .oe_n(oe_n), .sleep(sleep),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  localparam logic [3:0]  T_ADDR [8] = '{4'd3, 4'd5, 4'd3, 4'd5, 4'd3, 4'd5, 4'd5, 4'd0};
  localparam logic [35:0] T_DATA [8] = '{36'h1_2345_6789, 36'hA_BCDE_F012,
                                         36'hF_FFFF_FFFF, 36'h0_0000_0000,
                                         36'h5_5555_5555, 36'h9_8765_4321,
                                         36'h3_C3C3_C3C3, 36'h7_0F0F_0F0F};
  localparam logic        T_GW   [8] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam logic        T_BW   [8] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic [3:0]  T_BSEL [8] = '{4'hF, 4'h0, 4'b1010, 4'b0101,
                                         4'b0000, 4'b1111, 4'b0111, 4'hF};

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [39:0] act,
                     input logic [39:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c0, input logic c1, input logic c2,
                       input logic rq, input logic [AW-1:0] a, input logic gw,
                       input logic bw, input logic [3:0] bs, input logic [DW-1:0] d);
    cs0_n = c0; cs1 = c1; cs2_n = c2; req_n = rq; addr = a;
    gwe_n = gw; bwe_n = bw; bsel_n = bs; dq_in = d;
  endtask

  task automatic idle_sel();
    drive(1'b0, 1'b1, 1'b0, 1'b1, '0, 1'b1, 1'b1, 4'hF, '0);
  endtask

  task automatic desel();
    drive(1'b1, 1'b0, 1'b1, 1'b1, '0, 1'b1, 1'b1, 4'hF, '0);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    drive(1'b0, 1'b1, 1'b0, 1'b0, a, 1'b1, 1'b1, 4'hF, '0);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic gw, input logic bw,
                    input logic [3:0] bs, input logic [DW-1:0] d);
    drive(1'b0, 1'b1, 1'b0, 1'b0, a, gw, bw, bs, d);
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
      input logic [DW-1:0] d, input logic gw, input logic bw, input logic [3:0] bs);
    logic [DW-1:0] r = old;
    for (int i = 0; i < 4; i++)
      if (!gw || (!bw && !bs[i])) r[i*9 +: 9] = d[i*9 +: 9];
    return r;
  endfunction

  // read issued now, one selected idle cycle, then sample
  task automatic read_exp(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                          input string req);
    rd(a); step();
    idle_sel(); step();
    chk(dq_oe === 1'b1 && dq_out === exp, req, {3'b0, dq_oe, dq_out},
        {4'b0001, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R12 reset state
    desel();
    repeat (3) step();
    chk(dq_oe === 1'b0, "R12 in reset", {39'b0, dq_oe}, 40'd0);
    rst_n = 1'b1;
    chk(dq_oe === 1'b0, "R12 after reset", {39'b0, dq_oe}, 40'd0);
    idle_sel(); step();

    // Table: write then read back immediately (R1 R10, lanes per R2/R3/R4)
    for (int k = 0; k < 8; k++) begin
      wr(T_ADDR[k], T_GW[k], T_BW[k], T_BSEL[k], T_DATA[k]);
      step();
      model[T_ADDR[k]] = merge(model[T_ADDR[k]], T_DATA[k], T_GW[k], T_BW[k], T_BSEL[k]);
      read_exp(T_ADDR[k], model[T_ADDR[k]], "R1 R10 R2/R3/R4 table");
    end

    // R6 first read after a deselected cycle is masked
    desel(); step();
    rd(4'd3); step();
    idle_sel(); step();
    chk(dq_oe === 1'b0, "R6 masked first read", {39'b0, dq_oe}, 40'd0);
    read_exp(4'd3, model[3], "R6 second read drives");

    // R5 write captured while read result pending
    rd(4'd5); step();
    wr(4'd6, 1'b0, 1'b1, 4'hF, 36'h2_4681_3579); step();
    model[6] = 36'h2_4681_3579;
    chk(dq_oe === 1'b0, "R5 write forces hiz", {39'b0, dq_oe}, 40'd0);
    idle_sel(); step();

    // R11 asynchronous output enable
    rd(4'd6); step();
    idle_sel(); step();
    oe_n = 1'b1; #1;
    chk(dq_oe === 1'b0, "R11 oe_n high", {39'b0, dq_oe}, 40'd0);
    oe_n = 1'b0; #1;
    chk(dq_oe === 1'b1 && dq_out === model[6], "R11 oe_n low",
        {3'b0, dq_oe, dq_out}, {4'b0001, model[6]});
    step();

    // R7 one inactive chip select blocks the write
    for (int k = 0; k < 3; k++) begin
      drive(k == 0, k != 1, k == 2, 1'b0, 4'd3, 1'b0, 1'b1, 4'hF, 36'hD_EADB_EEF0);
      step();
      idle_sel(); step();
      read_exp(4'd3, model[3], "R7 partial select");
    end

    // R8 sleep entered while deselected
    desel(); sleep = 1'b1; step();
    wr(4'd0, 1'b0, 1'b1, 4'hF, 36'h1_1111_1111); step();
    rd(4'd0); step();
    idle_sel(); step();
    chk(dq_oe === 1'b0, "R8 asleep quiet", {39'b0, dq_oe}, 40'd0);

    // R9 two ignored cycles after wake
    sleep = 1'b0; idle_sel(); step();
    wr(4'd0, 1'b0, 1'b1, 4'hF, 36'h1_1111_1111); step();
    wr(4'd0, 1'b0, 1'b1, 4'hF, 36'h1_1111_1111); step();
    wr(4'd8, 1'b0, 1'b1, 4'hF, 36'h8_0808_0808); step();
    model[8] = 36'h8_0808_0808;
    read_exp(4'd0, model[0], "R8 R9 writes ignored");
    read_exp(4'd8, model[8], "R9 third cycle accepted");

    // R8 sleep request while selected is refused
    sleep = 1'b1;
    wr(4'd9, 1'b0, 1'b1, 4'hF, 36'h9_9999_0000); step();
    sleep = 1'b0;
    model[9] = 36'h9_9999_0000;
    idle_sel(); step();
    read_exp(4'd9, model[9], "R8 entry refused");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule